// File: doc/BRIEF.md
# Priority-Sorting Interrupt Controller

This block collects level-sensitive interrupt requests from up to 128 sources, grouped in banks of 32, and raises a single interrupt line to a processor. Each source has a mask bit and a priority level. A global threshold can also hold back sources whose priority value is too large. When the controller is idle and at least one source is eligible, it starts a sort of fixed length. The sort chooses the source with the smallest priority value, and the lowest source number wins a tie. At the end of the sort the controller checks its choice again. If the chosen source has gone away, the result is marked spurious.

Software reaches the block through a simple word-wide register port. A read returns its data one clock after the read strobe. Software reads the sorted-result register after the interrupt line rises, services the source, clears it, and then writes the acknowledge bit. The acknowledge drops the line and lets a new sort begin. The port also gives access to a revision byte, a soft-reset request with a completion flag, mask registers with write-one-to-set and write-one-to-clear aliases, read-only pending registers, and per-source level registers. The protection, idle and fast-interrupt routing fields are stored and read back but have no other effect.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt line is low, every mask bit is 1 (masked), every priority is 0, the threshold at 0x068 reads 0xFF, and bit 0 of the status word at 0x014 reads 1.
- R2: The pending word of bank b, at 0x098 + 0x20*b, reads as the source levels of that bank AND NOT its mask bits. It is read-only and is not affected by the threshold.
- R3: The mask word of bank b sits at 0x084 + 0x20*b and is read/write. Writing 1s at 0x088 + 0x20*b clears those mask bits, and writing 1s at 0x08C + 0x20*b sets them. Bits written as 0 through the aliases are left unchanged.
- R4: When the controller is idle and some source is eligible at a clock edge, a sort starts at that edge. The interrupt line rises at the SORT_LEN-th edge after it (default 10) and stays low during the sort.
- R5: The sorted word at 0x040 gives the winning source number in bits 6:0. The winner is the eligible source with the smallest priority, which is held in bits 7:2 of the level word at 0x100 + 4*n. On equal priority the lowest source number wins.
- R6: A source is eligible only when it is asserted, unmasked, and its priority is strictly below the threshold held in bits 7:0 of 0x068. With the threshold at 0 nothing is eligible and the line stays low.
- R7: If the chosen source is no longer eligible at the end of the sort (it dropped, was masked or was blocked by the threshold), bits 31:7 of the sorted word read all ones. Otherwise they read zero. The interrupt line rises in both cases.
- R8: Once raised, the interrupt line and the reported source number stay unchanged until a write with bit 0 set reaches 0x048. The line is low from the clock after that write.
- R9: The acknowledge clears the spurious marking. If an eligible source is still present, the next sort starts at the edge after the acknowledge, so the line rises again SORT_LEN+1 edges after the acknowledge edge.
- R10: Writing bit 1 of 0x010 restores the state of R1 and holds it for SRST_LEN cycles. During that time bit 0 of 0x014 reads 0 and writes are ignored; afterwards it reads 1. Bit 0 of 0x010 is a stored flag that reads back what was written and clears on soft reset.
- R11: The low byte of the revision word at 0x000 reads {REV_MAJOR, REV_MINOR}, which is 0x50 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Level interrupt requests, synchronous to clk |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data is returned the following cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the source levels and the bus strobes are synchronous to the clock. They also assume that an acknowledge or a soft-reset request is the only way software ends a raised interrupt. The bench changes all inputs on the falling clock edge and issues one single-cycle strobe at a time. It drops or masks a source during a sort only in the directed spurious cases. Before every acknowledge it clears the sources, except in the re-arm case, where it deliberately keeps one source asserted.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int BANK_W = 32;
  localparam int ID_W   = 7;

  localparam logic [11:0] A_REV    = 12'h000;
  localparam logic [11:0] A_SYSCFG = 12'h010;
  localparam logic [11:0] A_STATUS = 12'h014;
  localparam logic [11:0] A_SORTED = 12'h040;
  localparam logic [11:0] A_CTRL   = 12'h048;
  localparam logic [11:0] A_PROT   = 12'h04C;
  localparam logic [11:0] A_IDLE   = 12'h050;
  localparam logic [11:0] A_THR    = 12'h068;
  localparam logic [11:0] A_BANK0  = 12'h080;
  localparam logic [11:0] A_LEVEL0 = 12'h100;

  // offsets inside one 0x20-byte bank window
  localparam logic [4:0] B_MASK = 5'h04;
  localparam logic [4:0] B_CLR  = 5'h08;
  localparam logic [4:0] B_SET  = 5'h0C;
  localparam logic [4:0] B_PEND = 5'h18;

  typedef enum logic [1:0] {S_IDLE, S_SORT, S_HOLD} sort_state_e;
endpackage

// File: rtl/prio_intc_mask_bank.sv
module prio_intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         wr_mask,
  input  logic         wr_clr,
  input  logic         wr_set,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (clr)          mask_q <= '1;
    else if (wr_mask) mask_q <= wdata;
    else if (wr_clr)  mask_q <= mask_q & ~wdata;
    else if (wr_set)  mask_q <= mask_q | wdata;
  end

  assign pend = src & ~mask_q;
endmodule

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 6,
  parameter int ID_W    = 7
) (
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      any,
  output logic [ID_W-1:0]           win_id
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: equal priority keeps the lower index
  always_comb begin
    any    = 1'b0;
    best   = '1;
    win_id = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!any || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
        any    = 1'b1;
        best   = prio_flat[i*PRIO_W +: PRIO_W];
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc_sorter.sv
module prio_intc_sorter
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC  = 128,
  parameter int SORT_LEN = 10,
  parameter int ID_W     = 7
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               any_elig,
  input  logic [ID_W-1:0]    win_id,
  input  logic [NUM_SRC-1:0] elig,
  input  logic               ack,
  output logic               irq_q,
  output logic               busy,
  output logic [ID_W-1:0]    res_id,
  output logic               res_spur
);
  localparam int CNT_W = (SORT_LEN > 2) ? $clog2(SORT_LEN) : 1;
  localparam int PAD   = 2 ** ID_W;

  sort_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [ID_W-1:0]   cand;
  logic [PAD-1:0]    elig_w;

  always_comb begin
    elig_w = '0;
    elig_w[NUM_SRC-1:0] = elig;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cand     <= '0;
      irq_q    <= 1'b0;
      res_id   <= '0;
      res_spur <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (any_elig) begin
          state <= S_SORT;
          cnt   <= '0;
          cand  <= win_id;
        end
        S_SORT: if (cnt == CNT_W'(SORT_LEN - 1)) begin
          state    <= S_HOLD;
          irq_q    <= 1'b1;
          res_id   <= cand;
          res_spur <= !elig_w[cand];
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_HOLD: if (ack) begin
          state    <= S_IDLE;
          irq_q    <= 1'b0;
          res_spur <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_SORT);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int         NUM_SRC   = 128,
  parameter int         PRIO_W    = 6,
  parameter int         SORT_LEN  = 10,
  parameter int         SRST_LEN  = 8,
  parameter logic [3:0] REV_MAJOR = 4'd5,
  parameter logic [3:0] REV_MINOR = 4'd0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [11:0]        bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam int NUM_BANK = NUM_SRC / BANK_W;
  localparam int BANK_IW  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam int SRC_IW   = $clog2(NUM_SRC);
  localparam int SRST_W   = $clog2(SRST_LEN + 1);

  // soft reset sequencing
  logic [SRST_W-1:0] srst_cnt;
  logic              srst_busy, srst_req, clr, wr_ok;

  assign srst_busy = (srst_cnt != '0);
  assign wr_ok     = bus_wr && !srst_busy;
  assign srst_req  = wr_ok && (bus_addr == A_SYSCFG) && bus_wdata[1];
  assign clr       = rst || srst_busy || srst_req;

  always_ff @(posedge clk) begin
    if (rst)           srst_cnt <= '0;
    else if (srst_req) srst_cnt <= SRST_W'(SRST_LEN);
    else if (srst_busy) srst_cnt <= srst_cnt - 1'b1;
  end

  // address decode
  logic [11:0]        lvl_off, bank_off;
  logic               lvl_hit, bank_hit;
  logic [SRC_IW-1:0]  lvl_sel;
  logic [BANK_IW-1:0] bank_sel;
  logic [4:0]         bank_sub;

  assign lvl_off  = bus_addr - A_LEVEL0;
  assign lvl_hit  = (bus_addr >= A_LEVEL0) && (lvl_off[11:2] < 10'(NUM_SRC)) &&
                    (lvl_off[1:0] == 2'b00);
  assign lvl_sel  = lvl_off[SRC_IW+1:2];
  assign bank_off = bus_addr - A_BANK0;
  assign bank_hit = (bus_addr >= A_BANK0) && (bus_addr < A_LEVEL0) &&
                    (bank_off[11:5] < 7'(NUM_BANK));
  assign bank_sel = bank_off[BANK_IW+4:5];
  assign bank_sub = bank_off[4:0];

  // plain storage and configuration
  logic              autoidle_q, prot_q;
  logic [1:0]        idle_q;
  logic [7:0]        thr_q;
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic              fiq_q  [NUM_SRC];

  always_ff @(posedge clk) begin
    if (clr) begin
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= '0;
      thr_q      <= 8'hFF;
    end else if (wr_ok) begin
      case (bus_addr)
        A_SYSCFG: autoidle_q <= bus_wdata[0];
        A_PROT:   prot_q     <= bus_wdata[0];
        A_IDLE:   idle_q     <= bus_wdata[1:0];
        A_THR:    thr_q      <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= '0;
        fiq_q[i]  <= 1'b0;
      end
    end else if (wr_ok && lvl_hit) begin
      prio_q[lvl_sel] <= bus_wdata[PRIO_W+1:2];
      fiq_q[lvl_sel]  <= bus_wdata[0];
    end
  end

  // mask banks
  logic [NUM_SRC-1:0] mask_flat, pend_flat, elig;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic hit_b;
    assign hit_b = wr_ok && bank_hit && (bank_off[11:5] == 7'(b));
    prio_intc_mask_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .clr     (clr),
      .wr_mask (hit_b && (bank_sub == B_MASK)),
      .wr_clr  (hit_b && (bank_sub == B_CLR)),
      .wr_set  (hit_b && (bank_sub == B_SET)),
      .wdata   (bus_wdata),
      .src     (irq_src[b*BANK_W +: BANK_W]),
      .mask_q  (mask_flat[b*BANK_W +: BANK_W]),
      .pend    (pend_flat[b*BANK_W +: BANK_W])
    );
  end

  // eligibility and sorting
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    assign elig[i] = pend_flat[i] && (8'(prio_q[i]) < thr_q);
  end

  logic            any_elig, ack, sort_busy, res_spur, irq_q;
  logic [ID_W-1:0] win_id, res_id;

  assign ack = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];

  prio_intc_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
    .elig      (elig),
    .prio_flat (prio_flat),
    .any       (any_elig),
    .win_id    (win_id)
  );

  prio_intc_sorter #(.NUM_SRC(NUM_SRC), .SORT_LEN(SORT_LEN), .ID_W(ID_W)) u_sort (
    .clk      (clk),
    .clr      (clr),
    .any_elig (any_elig),
    .win_id   (win_id),
    .elig     (elig),
    .ack      (ack),
    .irq_q    (irq_q),
    .busy     (sort_busy),
    .res_id   (res_id),
    .res_spur (res_spur)
  );

  assign irq_out = irq_q;

  // read path
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (lvl_hit) begin
      rd_val = {{(30-PRIO_W){1'b0}}, prio_q[lvl_sel], 1'b0, fiq_q[lvl_sel]};
    end else if (bank_hit) begin
      if (bank_sub == B_MASK)      rd_val = mask_flat[{bank_sel, 5'b0} +: BANK_W];
      else if (bank_sub == B_PEND) rd_val = pend_flat[{bank_sel, 5'b0} +: BANK_W];
    end else begin
      case (bus_addr)
        A_REV:    rd_val = {24'h0, REV_MAJOR, REV_MINOR};
        A_SYSCFG: rd_val = {31'h0, autoidle_q};
        A_STATUS: rd_val = {31'h0, !srst_busy};
        A_SORTED: rd_val = {{(32-ID_W){res_spur}}, res_id};
        A_PROT:   rd_val = {31'h0, prot_q};
        A_IDLE:   rd_val = {30'h0, idle_q};
        A_THR:    rd_val = {24'h0, thr_q};
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int SORT_LEN = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_out,
  input logic            bus_wr,
  input logic [11:0]     bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            sort_busy,
  input logic [ID_W-1:0] res_id,
  input logic            srst_busy
);
  localparam int RUN_W = $clog2(SORT_LEN + 2);

  logic             ack_seen, srst_seen;
  logic [RUN_W-1:0] run_len;

  assign ack_seen  = bus_wr && !srst_busy && (bus_addr == A_CTRL) && bus_wdata[0];
  assign srst_seen = bus_wr && !srst_busy && (bus_addr == A_SYSCFG) && bus_wdata[1];

  // length of the current uninterrupted sorting run
  always_ff @(posedge clk) begin
    if (rst)                                run_len <= '0;
    else if (!sort_busy)                    run_len <= '0;
    else if (run_len != RUN_W'(SORT_LEN + 1)) run_len <= run_len + 1'b1;
  end

  a_r4_sort_length: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> (run_len == RUN_W'(SORT_LEN)));

  a_r4_low_while_sorting: assert property (@(posedge clk) disable iff (rst)
    sort_busy |-> !irq_out);

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack_seen && !srst_seen) |=> irq_out);

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (irq_out && ack_seen) |=> !irq_out);

  a_r8_id_stable: assert property (@(posedge clk) disable iff (rst)
    irq_out |=> (!irq_out || $stable(res_id)));

  a_r10_quiet_in_srst: assert property (@(posedge clk) disable iff (rst)
    srst_busy |-> (!irq_out && !sort_busy));
endmodule

bind prio_intc prio_intc_chk #(.SORT_LEN(SORT_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sort_busy (sort_busy),
  .res_id    (res_id),
  .srst_busy (srst_busy)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int NS = 128;
  localparam int SL = 10;
  localparam int SR = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic [11:0]   addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  always #4 clk = ~clk;

  prio_intc #(.NUM_SRC(NS), .SORT_LEN(SL), .SRST_LEN(SR)) u0 (
    .clk(clk), .rst(rst), .irq_src(src), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq_out(irq)
  );

  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  logic [NS-1:0] m_mask;
  int          m_prio [NS];
  int          m_thr;
  logic [31:0] v;
  int          w;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic model_reset();
    m_mask = '1;
    m_thr  = 255;
    for (int i = 0; i < NS; i++) m_prio[i] = 0;
  endtask

  task automatic set_prio(int i, int p);
    m_prio[i] = p;
    wr_reg(12'(32'h100 + 4 * i), 32'(p << 2));
  endtask

  task automatic set_mask(int b, logic [31:0] mv);
    m_mask[b*32 +: 32] = mv;
    wr_reg(12'(32'h084 + 32 * b), mv);
  endtask

  task automatic set_thr(int t);
    m_thr = t;
    wr_reg(12'h068, 32'(t));
  endtask

  task automatic ack();
    wr_reg(12'h048, 32'h1);
  endtask

  function automatic int exp_win();
    int best = -1;
    for (int i = 0; i < NS; i++)
      if (src[i] && !m_mask[i] && (m_prio[i] < m_thr) &&
          ((best < 0) || (m_prio[i] < m_prio[best])))
        best = i;
    return best;
  endfunction

  // call at the falling edge on which the sort-starting input change was made
  task automatic wait_sort(string req);
    for (int k = 1; k <= SL + 1; k++) begin
      @(negedge clk);
      if (k == SL)     chk(req, 32'(irq), 32'd0);
      if (k == SL + 1) chk(req, 32'(irq), 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R11 reset state
    chk("R1 irq low after reset", 32'(irq), 32'd0);
    rd_reg(12'h000, v); chk("R11 revision byte", v, 32'h50);
    rd_reg(12'h014, v); chk("R1 reset done flag", v, 32'h1);
    rd_reg(12'h084, v); chk("R1 masks all set", v, 32'hFFFF_FFFF);
    rd_reg(12'h068, v); chk("R1 threshold 0xFF", v, 32'hFF);
    rd_reg(12'h114, v); chk("R1 priority zero", v, 32'h0);

    // R3 mask aliases
    wr_reg(12'h088, 32'h0000_00F0);
    rd_reg(12'h084, v); chk("R3 clear alias", v, 32'hFFFF_FF0F);
    wr_reg(12'h08C, 32'h0000_0030);
    rd_reg(12'h084, v); chk("R3 set alias", v, 32'hFFFF_FF3F);
    wr_reg(12'h0E4, 32'h1234_5678);
    rd_reg(12'h0E4, v); chk("R3 direct write bank3", v, 32'h1234_5678);
    for (int b = 0; b < 4; b++) set_mask(b, 32'h0);

    // R2 / R6 pending ignores threshold; threshold 0 blocks all
    set_mask(0, 32'h0000_FFFF);
    set_thr(0);
    src[31:0] = 32'hA5A5_5A5A;
    repeat (SL + 3) @(negedge clk);
    chk("R6 threshold zero keeps line low", 32'(irq), 32'd0);
    rd_reg(12'h098, v); chk("R2 pending = src & ~mask", v, 32'hA5A5_0000);
    src = '0;
    set_thr(255);
    set_mask(0, 32'h0);

    // R4 / R5 priority winner
    set_prio(5, 3);
    set_prio(9, 1);
    rd_reg(12'h124, v); chk("R5 level readback", v, 32'h04);
    src[5] = 1'b1; src[9] = 1'b1;
    wait_sort("R4 sort length");
    rd_reg(12'h040, v); chk("R5 lower value wins", v, 32'd9);
    src = '0; ack();
    chk("R8 ack drops line", 32'(irq), 32'd0);

    set_prio(9, 3);
    src[5] = 1'b1; src[9] = 1'b1;
    wait_sort("R4 sort length tie");
    rd_reg(12'h040, v); chk("R5 tie to lowest number", v, 32'd5);
    src = '0; ack();

    // R7 spurious by deassertion
    src[20] = 1'b1;
    repeat (3) @(negedge clk);
    src[20] = 1'b0;
    repeat (SL + 1 - 3) @(negedge clk);
    chk("R7 line rises on spurious", 32'(irq), 32'd1);
    rd_reg(12'h040, v); chk("R7 spurious after drop", v, 32'hFFFF_FF94);
    ack();
    chk("R8 ack drops line after spurious", 32'(irq), 32'd0);
    rd_reg(12'h040, v); chk("R9 ack clears spurious", v, 32'd20);

    // R7 spurious by masking mid-sort
    src[33] = 1'b1;
    repeat (3) @(negedge clk);
    wr_reg(12'h0AC, 32'h2); m_mask[33] = 1'b1;
    repeat (SL + 1 - 4) @(negedge clk);
    chk("R7 line rises after mask", 32'(irq), 32'd1);
    rd_reg(12'h040, v); chk("R7 spurious after mask", v, 32'hFFFF_FFA1);
    src = '0; ack();
    wr_reg(12'h0A8, 32'h2); m_mask[33] = 1'b0;

    // R8 hold until ack
    src[7] = 1'b1;
    wait_sort("R4 sort length hold case");
    src = '0;
    repeat (6) @(negedge clk);
    chk("R8 line held without ack", 32'(irq), 32'd1);
    rd_reg(12'h040, v); chk("R8 result held", v, 32'd7);
    ack();
    chk("R8 ack releases line", 32'(irq), 32'd0);

    // R9 re-arm with source still present
    src[40] = 1'b1;
    wait_sort("R4 sort length rearm");
    ack();
    chk("R9 line low right after ack", 32'(irq), 32'd0);
    wait_sort("R9 rearm timing");
    rd_reg(12'h040, v); chk("R9 rearm result", v, 32'd40);
    src = '0; ack();

    // R6 threshold selection
    set_prio(59, 12); set_prio(60, 10); set_prio(61, 20);
    set_thr(15);
    src[59] = 1'b1; src[60] = 1'b1; src[61] = 1'b1;
    wait_sort("R4 sort length threshold");
    rd_reg(12'h040, v); chk("R6 threshold winner", v, 32'd60);
    src = '0; ack();
    set_thr(10);
    src[59] = 1'b1; src[60] = 1'b1; src[61] = 1'b1;
    repeat (SL + 3) @(negedge clk);
    chk("R6 all blocked by threshold", 32'(irq), 32'd0);
    src = '0;
    set_thr(255);

    // random trials
    for (int t = 0; t < 24; t++) begin
      logic [NS-1:0] s;
      for (int b = 0; b < 4; b++) set_mask(b, $urandom & $urandom);
      for (int i = 0; i < NS; i++)
        set_prio(i, (t % 2 == 1) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 63)));
      set_thr((t % 3 == 0) ? int'($urandom_range(1, 40)) : 255);
      for (int i = 0; i < NS; i++) s[i] = ($urandom_range(0, 7) == 0);
      src = s;
      w = exp_win();
      if (w >= 0) begin
        int bk;
        wait_sort("R4 random sort length");
        rd_reg(12'h040, v); chk("R5 random winner", v, 32'(w));
        bk = int'($urandom_range(0, 3));
        rd_reg(12'(32'h098 + 32 * bk), v);
        chk("R2 random pending", v, src[bk*32 +: 32] & ~m_mask[bk*32 +: 32]);
        src = '0; ack();
        chk("R8 random ack", 32'(irq), 32'd0);
      end else begin
        repeat (SL + 3) @(negedge clk);
        chk("R6 random nothing eligible", 32'(irq), 32'd0);
        src = '0;
      end
    end

    // R10 soft reset
    set_mask(0, 32'h0);
    set_thr(200);
    wr_reg(12'h010, 32'h1);
    rd_reg(12'h010, v); chk("R10 stored flag", v, 32'h1);
    src[3] = 1'b1;
    wait_sort("R4 sort length before soft reset");
    wr_reg(12'h010, 32'h2);
    chk("R10 soft reset drops line", 32'(irq), 32'd0);
    rd_reg(12'h014, v); chk("R10 busy during soft reset", v, 32'h0);
    repeat (SR + 2) @(negedge clk);
    rd_reg(12'h014, v); chk("R10 done after soft reset", v, 32'h1);
    model_reset();
    rd_reg(12'h010, v); chk("R10 flag cleared", v, 32'h0);
    rd_reg(12'h084, v); chk("R10 masks restored", v, 32'hFFFF_FFFF);
    rd_reg(12'h068, v); chk("R10 threshold restored", v, 32'hFF);
    rd_reg(12'h1F0, v); chk("R10 priority restored", v, 32'h0);
    repeat (SL + 3) @(negedge clk);
    chk("R10 masked source stays quiet", 32'(irq), 32'd0);
    src = '0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule